// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This engine sends frames whose layout is held in system memory as a linked list of transmit descriptors. Software builds the list, hands each descriptor to the engine by setting its owner bit, loads the list head, turns transmission on and rings a doorbell. The engine then fetches each descriptor over a 32-bit memory master port. It streams the descriptor's buffer out as bytes, writes completion status back and returns the descriptor to software. It then follows the next pointer.

The walk ends at the first descriptor that software still owns. The engine then raises a descriptor-unavailable flag and parks its current pointer on that entry. A later doorbell re-reads the same entry, so software can extend the list and resume. Interrupt flags are write-one-to-clear. A single interrupt line is the OR of every flag whose enable bit is set.

Register map (word index on `reg_addr_i`):
- 0: control, with transmit-on at bit 8.
- 1: list start address.
- 2: doorbell. Any write rings it, and it reads as 0.
- 3: interrupt enable.
- 4: interrupt status.
- 5: current descriptor address, read only.
- 6: current buffer address, read only.

Each descriptor is four little-endian words at offsets +0, +4, +8 and +12:
- +0: flags. Bit 31 is the owner (1 = engine). Bit 2 is the per-descriptor interrupt enable.
- +4: buffer start address.
- +8: status and length. The length is in bits 15:0.
- +12: next descriptor address.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset the registers read as follows: control 0, list start 0xFFFFFFFC, current descriptor 0, current buffer 0, interrupt status 0. `irq_o` is 0.
- R2: A walk step reads the words at D, D+4, D+8 and D+12 of the current descriptor D. The memory request holds its address and controls until `mem_ready_i` is seen.
- R3: A frame emits exactly the number of bytes given by bits 15:0 of the status-and-length word. The bytes come from aligned 32-bit fetches, low byte first, starting at the byte lane given by the buffer address bits 1:0. `tx_last_o` marks only the final byte, and data holds while `tx_ready_i` is low.
- R4: After a frame the engine first writes the status word at D+8 with bit 19 set, and bit 16 set only if flags bit 2 was set. It then writes the flags word at D with bit 31 cleared and the other bits unchanged.
- R5: The engine then continues at the next pointer. On fetching flags with bit 31 clear it stops, writes nothing to that descriptor and sets status bit 23. The current descriptor register then holds that descriptor's address.
- R6: Each completed descriptor sets status bit 18. Bit 16 is set only by completed descriptors whose flags bit 2 was set.
- R7: `irq_o` is 1 exactly when some interrupt status bit and the same bit of the interrupt enable register are both 1.
- R8: Writing 1 to an interrupt status bit clears it. Writing 0 leaves it unchanged.
- R9: A doorbell write starts a walk only when transmit-on is set and the engine is idle. A doorbell write during a walk, or with transmit-on clear, has no effect.
- R10: Setting transmit-on from 0 to 1 while idle loads the current descriptor from the list start. A doorbell after a halt re-reads the descriptor at the current pointer and checks its owner bit again.
- R11: A descriptor of length 0 emits no bytes but is still written back and completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory request |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the request |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_ready_i | input | 1 | Sink accepts the byte |
| tx_last_o | output | 1 | Final byte of the frame |
| irq_o | output | 1 | Transmit interrupt |

## Verification
The bench walks a three-entry chain with random memory and stream stalls. The second buffer starts at an odd byte address, so a design that ignored the start lane would emit the wrong first byte or one byte too many. A second doorbell is rung mid-walk: an engine that restarted on it would emit the frames twice and write back twice. A halt followed by software handing over the halting entry checks that the ownership test is re-done, and that a zero-length entry still completes without emitting bytes. A doorbell with transmit-on clear, and write-one-to-clear with mixed bit patterns, check that state that should not move does not move.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int FLG_OWN  = 31;
  localparam int FLG_IEN  = 2;
  localparam int STS_DONE = 19;
  localparam int STS_INTR = 16;
  localparam int IS_UNAV  = 23;
  localparam int IS_CMPL  = 18;
  localparam int IS_INTR  = 16;
  localparam logic [31:0] IS_MASK = (32'd1 << IS_UNAV) | (32'd1 << IS_CMPL) | (32'd1 << IS_INTR);

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_LIST  = 3'd1;
  localparam logic [2:0] RA_BELL  = 3'd2;
  localparam logic [2:0] RA_IEN   = 3'd3;
  localparam logic [2:0] RA_ISTAT = 3'd4;
  localparam logic [2:0] RA_CDESC = 3'd5;
  localparam logic [2:0] RA_CBUF  = 3'd6;
  localparam int CTRL_TXON = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FLAGS, ST_BUF, ST_LEN, ST_NEXT,
    ST_DATA, ST_SEND, ST_WSTAT, ST_WFLAG
  } walk_state_e;
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs
  import tdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          busy_i,
  input  logic [AW-1:0] cur_desc_i,
  input  logic [AW-1:0] cur_buf_i,
  input  logic          done_i,
  input  logic          intr_i,
  input  logic          unavail_i,
  output logic          go_o,
  output logic          load_o,
  output logic [AW-1:0] list_start_o,
  output logic          irq_o
);
  logic          tx_on_q;
  logic [AW-1:0] list_q;
  logic [31:0]   ien_q, istat_q, istat_d;

  wire wr_ctrl  = reg_wr_i && reg_addr_i == RA_CTRL;
  wire wr_istat = reg_wr_i && reg_addr_i == RA_ISTAT;

  assign go_o         = reg_wr_i && reg_addr_i == RA_BELL && tx_on_q && !busy_i;
  assign load_o       = wr_ctrl && reg_wdata_i[CTRL_TXON] && !tx_on_q;
  assign list_start_o = list_q;
  assign irq_o        = |(istat_q & ien_q);

  always_comb begin
    istat_d = istat_q;
    if (wr_istat) istat_d = istat_d & ~reg_wdata_i;
    if (done_i)    istat_d[IS_CMPL] = 1'b1;
    if (intr_i)    istat_d[IS_INTR] = 1'b1;
    if (unavail_i) istat_d[IS_UNAV] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_on_q <= 1'b0;
      list_q  <= {{(AW-2){1'b1}}, 2'b00};
      ien_q   <= '0;
      istat_q <= '0;
    end else begin
      if (wr_ctrl) tx_on_q <= reg_wdata_i[CTRL_TXON];
      if (reg_wr_i && reg_addr_i == RA_LIST) list_q <= reg_wdata_i[AW-1:0];
      if (reg_wr_i && reg_addr_i == RA_IEN)  ien_q  <= reg_wdata_i;
      istat_q <= istat_d & IS_MASK;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CTRL:  reg_rdata_o[CTRL_TXON] = tx_on_q;
      RA_LIST:  reg_rdata_o = 32'(list_q);
      RA_IEN:   reg_rdata_o = ien_q;
      RA_ISTAT: reg_rdata_o = istat_q;
      RA_CDESC: reg_rdata_o = 32'(cur_desc_i);
      RA_CBUF:  reg_rdata_o = 32'(cur_buf_i);
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_UNAV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_i |=> istat_q[IS_UNAV]); // R5
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_istat && reg_wdata_i[IS_CMPL] && !done_i) |=> !istat_q[IS_CMPL]); // R8
  AST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_istat && !reg_wdata_i[IS_UNAV] && istat_q[IS_UNAV]) |=> istat_q[IS_UNAV]); // R8
endmodule

// File: rtl/tdma_walker.sv
module tdma_walker
  import tdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          load_i,
  input  logic [AW-1:0] list_start_i,
  output logic          busy_o,
  output logic [AW-1:0] cur_desc_o,
  output logic [AW-1:0] cur_buf_o,
  output logic          done_o,
  output logic          intr_o,
  output logic          unavail_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          tx_last_o
);
  walk_state_e   state_q;
  logic [AW-1:0] desc_q, buf_q, next_q, ptr_q;
  logic [31:0]   flags_q, stat_q, word_q;
  logic [LEN_W-1:0] rem_q;
  logic fire, tx_fire;

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q;
    mem_wdata_o = '0;
    case (state_q)
      ST_FLAGS: mem_addr_o = desc_q;
      ST_BUF:   mem_addr_o = desc_q + AW'(4);
      ST_LEN:   mem_addr_o = desc_q + AW'(8);
      ST_NEXT:  mem_addr_o = desc_q + AW'(12);
      ST_DATA:  mem_addr_o = {ptr_q[AW-1:2], 2'b00};
      ST_WSTAT: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + AW'(8);
        mem_wdata_o = stat_q;
        mem_wdata_o[STS_DONE] = 1'b1;
        if (flags_q[FLG_IEN]) mem_wdata_o[STS_INTR] = 1'b1;
      end
      ST_WFLAG: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = flags_q;
        mem_wdata_o[FLG_OWN] = 1'b0;
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  assign fire       = mem_req_o && mem_ready_i;
  assign tx_valid_o = state_q == ST_SEND;
  assign tx_fire    = tx_valid_o && tx_ready_i;
  assign tx_data_o  = word_q[{ptr_q[1:0], 3'b000} +: 8];
  assign tx_last_o  = tx_valid_o && rem_q == LEN_W'(1);
  assign done_o     = state_q == ST_WFLAG && fire;
  assign intr_o     = done_o && flags_q[FLG_IEN];
  assign unavail_o  = state_q == ST_FLAGS && fire && !mem_rdata_i[FLG_OWN];
  assign busy_o     = state_q != ST_IDLE;
  assign cur_desc_o = desc_q;
  assign cur_buf_o  = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      buf_q   <= '0;
      next_q  <= '0;
      ptr_q   <= '0;
      flags_q <= '0;
      stat_q  <= '0;
      word_q  <= '0;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_i) desc_q <= list_start_i;
          if (go_i) state_q <= ST_FLAGS;
        end
        ST_FLAGS: if (fire) begin
          flags_q <= mem_rdata_i;
          state_q <= mem_rdata_i[FLG_OWN] ? ST_BUF : ST_IDLE;
        end
        ST_BUF: if (fire) begin
          buf_q   <= mem_rdata_i[AW-1:0];
          ptr_q   <= mem_rdata_i[AW-1:0];
          state_q <= ST_LEN;
        end
        ST_LEN: if (fire) begin
          stat_q  <= mem_rdata_i;
          rem_q   <= mem_rdata_i[LEN_W-1:0];
          state_q <= ST_NEXT;
        end
        ST_NEXT: if (fire) begin
          next_q  <= mem_rdata_i[AW-1:0];
          state_q <= (rem_q == '0) ? ST_WSTAT : ST_DATA;
        end
        ST_DATA: if (fire) begin
          word_q  <= mem_rdata_i;
          state_q <= ST_SEND;
        end
        ST_SEND: if (tx_fire) begin
          rem_q <= rem_q - LEN_W'(1);
          ptr_q <= ptr_q + AW'(1);
          if (rem_q == LEN_W'(1))    state_q <= ST_WSTAT;
          else if (ptr_q[1:0] == 2'd3) state_q <= ST_DATA;
        end
        ST_WSTAT: if (fire) state_q <= ST_WFLAG;
        ST_WFLAG: if (fire) begin
          desc_q  <= next_q;
          state_q <= ST_FLAGS;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R2
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o))); // R3
  AST_LAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fire && tx_last_o) |=> !tx_valid_o); // R3
  AST_STOP_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o |=> (!busy_o && $stable(desc_q))); // R5
  AST_GO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> state_q == ST_IDLE); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, unavail_o})); // R6
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
  import tdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          tx_last_o,
  output logic          irq_o
);
  logic busy, go, load, done, intr, unavail;
  logic [AW-1:0] cur_desc, cur_buf, list_start;

  tdma_regs #(.AW(AW)) regs_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .cur_desc_i(cur_desc), .cur_buf_i(cur_buf),
    .done_i(done), .intr_i(intr), .unavail_i(unavail),
    .go_o(go), .load_o(load), .list_start_o(list_start), .irq_o
  );

  tdma_walker #(.AW(AW), .LEN_W(LEN_W)) walker_i (
    .clk_i, .rst_ni, .go_i(go), .load_i(load), .list_start_i(list_start),
    .busy_o(busy), .cur_desc_o(cur_desc), .cur_buf_o(cur_buf),
    .done_o(done), .intr_o(intr), .unavail_o(unavail),
    .mem_req_o, .mem_addr_o, .mem_we_o, .mem_wdata_o, .mem_rdata_i, .mem_ready_i,
    .tx_data_o, .tx_valid_o, .tx_ready_i, .tx_last_o
  );
endmodule

// File: tb/tx_desc_dma_tb.sv
module tx_desc_dma_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_ready = 1'b1, irq;

  logic [31:0] mem [256];
  logic [7:0]  cap_b [64];
  logic        cap_l [64];
  logic [31:0] wlog [32];
  int nbytes = 0, nwr = 0, total = 0, bad = 0;
  logic stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_desc_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_last_o(tx_last), .irq_o(irq)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ready) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      wlog[nwr[4:0]] <= mem_addr;
      nwr <= nwr + 1;
    end
    if (tx_valid && tx_ready) begin
      cap_b[nbytes[5:0]] <= tx_data;
      cap_l[nbytes[5:0]] <= tx_last;
      nbytes <= nbytes + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= stall ? lfsr[0] : 1'b1;
    tx_ready  <= stall ? lfsr[3] : 1'b1;
  end

  task automatic chk(input string req, input [31:0] got, input [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input [2:0] a, input [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input [2:0] a, output [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_unav();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd4, v);
      if (v[23]) break;
    end
  endtask

  task automatic put_desc(input int d, input [31:0] fl, input [31:0] bf,
                          input [31:0] sl, input [31:0] nx);
    mem[d>>2] = fl; mem[(d>>2)+1] = bf; mem[(d>>2)+2] = sl; mem[(d>>2)+3] = nx;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd1, v); chk("R1 list", v, 32'hFFFF_FFFC);
    rd(3'd5, v); chk("R1 cdesc", v, 32'h0);
    rd(3'd6, v); chk("R1 cbuf", v, 32'h0);
    rd(3'd4, v); chk("R1 istat", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    logic [7:0] exp_b [12];
    exp_b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
              8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7};
    put_desc(32'h100, 32'h8000_0004, 32'h200, 32'h5, 32'h110);
    put_desc(32'h110, 32'h8000_0000, 32'h301, 32'h7, 32'h120);
    put_desc(32'h120, 32'h0, 32'h200, 32'h0, 32'h130);
    mem[8'h80] = 32'h4433_2211; mem[8'h81] = 32'h0000_0055;
    mem[8'hC0] = 32'hA3A2_A1A0; mem[8'hC1] = 32'hA7A6_A5A4;
    stall = 1'b1;
    wr(3'd1, 32'h100);
    wr(3'd0, 32'h100);
    rd(3'd5, v); chk("R10 load", v, 32'h100);
    wr(3'd2, 32'h1);
    repeat (3) @(negedge clk);
    wr(3'd2, 32'h1);  // rung while walking
    wait_unav();
    stall = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 R9 byte count", nbytes, 12);
    for (int i = 0; i < 12; i++) begin
      chk("R3 byte", {24'b0, cap_b[i]}, {24'b0, exp_b[i]});
      chk("R3 last", {31'b0, cap_l[i]}, {31'b0, (i == 4 || i == 11)});
    end
    chk("R4 R9 write count", nwr, 4);
    chk("R4 order0", wlog[0], 32'h108);
    chk("R4 order1", wlog[1], 32'h100);
    chk("R4 order2", wlog[2], 32'h118);
    chk("R4 order3", wlog[3], 32'h110);
    chk("R4 stat0", mem[8'h42], 32'h0009_0005);
    chk("R4 flag0", mem[8'h40], 32'h0000_0004);
    chk("R4 stat1", mem[8'h46], 32'h0008_0007);
    chk("R4 flag1", mem[8'h44], 32'h0000_0000);
    chk("R5 untouched", mem[8'h48], 32'h0);
    rd(3'd5, v); chk("R5 cdesc", v, 32'h120);
    rd(3'd6, v); chk("R2 cbuf", v, 32'h301);
    rd(3'd4, v); chk("R6 istat", v, 32'h0085_0000);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(3'd3, 32'h0080_0000);
    chk("R7 irq unav", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h0004_0000);
    rd(3'd4, v); chk("R8 w1c", v, 32'h0081_0000);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R8 w0 keep", v, 32'h0081_0000);
    wr(3'd4, 32'h0080_0000);
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h0001_0000);
    chk("R7 irq intr", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R8 clear all", v, 32'h0);
    chk("R7 irq none", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_resume();
    logic [31:0] v;
    put_desc(32'h130, 32'h0, 32'h200, 32'h0, 32'h140);
    mem[8'h48] = 32'h8000_0000;  // hand over the halting entry, length 0
    wr(3'd2, 32'h1);
    wait_unav();
    chk("R11 no bytes", nbytes, 12);
    chk("R11 stat", mem[8'h4A], 32'h0008_0000);
    chk("R11 flag", mem[8'h48], 32'h0);
    chk("R10 writes", nwr, 6);
    rd(3'd5, v); chk("R10 R5 cdesc", v, 32'h130);
    rd(3'd4, v); chk("R6 no intr bit", v, 32'h0084_0000);
    wr(3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_txoff();
    logic [31:0] v;
    mem[8'h4C] = 32'h8000_0000;
    put_desc(32'h140, 32'h0, 32'h0, 32'h0, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h1);
    repeat (40) @(negedge clk);
    rd(3'd4, v); chk("R9 off istat", v, 32'h0);
    rd(3'd5, v); chk("R9 off cdesc", v, 32'h130);
    chk("R9 off writes", nwr, 6);
    wr(3'd1, 32'h1C0);
    rd(3'd5, v); chk("R10 no load while off", v, 32'h130);
    wr(3'd0, 32'h100);
    rd(3'd5, v); chk("R10 reload", v, 32'h1C0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chain();
    t_irq();
    t_resume();
    t_txoff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog got=%h exp=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule